// File: doc/BRIEF.md
# Light-Load Mode Sequencer for a Buck Regulator Channel

This block chooses, for a single switching regulator channel, between fixed-frequency PWM operation and pulse-frequency (PFM) operation. In PWM it watches two light-load indications at each PWM cycle tick, and it moves to PFM once the load has looked light for a set run of consecutive switching cycles. In PFM it drives the high-side and low-side gate requests itself as bursts of charge pulses, and between bursts it parks both switches in a low-power sleep state.

The comparator results come in as single-bit levels already synchronised to the clock. The PWM duty generator owns the gates while `pfm_mode` is low. A forced-PWM control bit, a heavy-load undervoltage indication and the channel enable each send the channel straight back to PWM.

Top module: `pfm_mode_ctrl`

## Requirements
- R1: After reset the channel is in PWM: `pfm_mode`, `hs_req`, `ls_req` and `sleep` are all 0.
- R2: On a cycle with `pwm_tick` high, the light-load condition is `zc_det` OR `pk_below_mode`. When this condition has held on QUAL_CYCLES consecutive ticks (default 32), `pfm_mode` is 1 from the clock edge that samples the last of those ticks. One tick fewer does not switch the mode.
- R3: A tick on which neither light-load input is high clears the run count, so a new full run of QUAL_CYCLES qualifying ticks is then needed.
- R4: Cycles without `pwm_tick` neither add to the run count nor clear it, whatever the light-load inputs are.
- R5: On entry to PFM the channel goes to the high-side pulse (`hs_req`=1) if `vo_above_hi` is 0, and to sleep (`sleep`=1) if it is 1.
- R6: `hs_req` stays high until `vo_above_hi` or `pk_at_pfm_lim` is seen. In the next cycle `ls_req` is high and `hs_req` is low.
- R7: `ls_req` stays high until `zc_det`. At that point the channel goes to sleep if the output is above the high threshold, or if the high-side pulse ended because the output crossed the high threshold. Otherwise it starts another high-side pulse.
- R8: In sleep both gate requests are low. `vo_below_lo` starts a new burst with `hs_req` high in the next cycle.
- R9: `vo_below_lo2` in any PFM state returns the channel to PWM in the next cycle. The run count then starts again from zero.
- R10: While `force_pwm` is 1, the channel leaves PFM in the next cycle and never enters it, and the run count is held at zero.
- R11: While `en` is 0, the channel is held in PWM with both gate requests low and the run count at zero.
- R12: `hs_req` and `ls_req` are never 1 in the same cycle. `sleep` is 1 only in PFM with both gate requests low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel enable |
| force_pwm | input | 1 | Control bit that holds the channel in PWM |
| pwm_tick | input | 1 | One-cycle pulse per PWM switching period |
| zc_det | input | 1 | Low-side current has reached zero |
| pk_below_mode | input | 1 | Peak high-side current is below the mode threshold |
| pk_at_pfm_lim | input | 1 | Peak current has reached the PFM limit |
| vo_above_hi | input | 1 | Output is above the high PFM threshold |
| vo_below_lo | input | 1 | Output is below the low PFM threshold |
| vo_below_lo2 | input | 1 | Output is below the low2 (return-to-PWM) threshold |
| pfm_mode | output | 1 | 1 in PFM, 0 in PWM |
| hs_req | output | 1 | High-side gate request in PFM |
| ls_req | output | 1 | Low-side gate request in PFM |
| sleep | output | 1 | Both switches parked, low-power wait |

## Verification
Two things are hard to reach from the ports. The first is each PFM sub-state under every combination of the exit inputs. The bench rebuilds the entry run of qualifying ticks before every single combination, then sweeps all 32 values of the five comparator inputs from both the sleep state and the high-side state, and computes the next outputs from the priority order in R5 to R9. The second is the exact tick boundary of the run count. The bench sweeps run lengths around QUAL_CYCLES, inserts idle non-tick cycles with the conditions low, and breaks a run one tick short, so that an off-by-one shows up as a wrong mode on a specific tick.

// File: rtl/pfm_mode_ctrl.sv
module pfm_mode_ctrl #(
  parameter int QUAL_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic force_pwm,
  input  logic pwm_tick,
  input  logic zc_det,
  input  logic pk_below_mode,
  input  logic pk_at_pfm_lim,
  input  logic vo_above_hi,
  input  logic vo_below_lo,
  input  logic vo_below_lo2,
  output logic pfm_mode,
  output logic hs_req,
  output logic ls_req,
  output logic sleep
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  typedef enum logic [2:0] {S_PWM, S_HS, S_LS, S_LS_FIN, S_SLEEP} st_t;

  st_t st, st_nx;
  logic [CW-1:0] run, run_nx;

  wire light   = zc_det | pk_below_mode;
  wire bail    = !en || force_pwm || vo_below_lo2;
  wire qualify = en && !force_pwm && pwm_tick && light;
  wire entry   = qualify && (run == LAST);

  always_comb begin
    st_nx  = st;
    run_nx = run;
    if (st == S_PWM) begin
      if (!en || force_pwm)    run_nx = '0;
      else if (pwm_tick)       run_nx = (light && !entry) ? run + 1'b1 : '0;
      if (entry)               st_nx = vo_above_hi ? S_SLEEP : S_HS;
    end else if (bail) begin
      st_nx  = S_PWM;
      run_nx = '0;
    end else begin
      unique case (st)
        S_HS:     if (vo_above_hi)        st_nx = S_LS_FIN;
                  else if (pk_at_pfm_lim) st_nx = S_LS;
        S_LS:     if (zc_det)             st_nx = vo_above_hi ? S_SLEEP : S_HS;
        S_LS_FIN: if (zc_det)             st_nx = S_SLEEP;
        S_SLEEP:  if (vo_below_lo)        st_nx = S_HS;
        default:                          st_nx = S_PWM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_PWM;
      run <= '0;
    end else begin
      st  <= st_nx;
      run <= run_nx;
    end
  end

  assign pfm_mode = (st != S_PWM);
  assign hs_req   = (st == S_HS);
  assign ls_req   = (st == S_LS) || (st == S_LS_FIN);
  assign sleep    = (st == S_SLEEP);
endmodule

// File: rtl/pfm_mode_ctrl_chk.sv
module pfm_mode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic force_pwm,
  input logic pwm_tick,
  input logic pk_at_pfm_lim,
  input logic vo_above_hi,
  input logic vo_below_lo,
  input logic vo_below_lo2,
  input logic pfm_mode,
  input logic hs_req,
  input logic ls_req,
  input logic sleep
);
  wire keep = en && !force_pwm && !vo_below_lo2;

  AST_GATES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_req && ls_req)); // R12
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (pfm_mode && !hs_req && !ls_req)); // R12
  AST_ENTRY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfm_mode) |-> $past(pwm_tick)); // R2
  AST_HS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_req && keep && !vo_above_hi && !pk_at_pfm_lim) |=> hs_req); // R6
  AST_HS_TO_LS: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_req && keep && (vo_above_hi || pk_at_pfm_lim)) |=> ls_req); // R6
  AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && keep && vo_below_lo) |=> hs_req); // R8
  AST_LO2_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pfm_mode && vo_below_lo2) |=> !pfm_mode); // R9
  AST_FORCE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    force_pwm |=> !pfm_mode); // R10
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pfm_mode && !hs_req && !ls_req)); // R11
endmodule

bind pfm_mode_ctrl pfm_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .force_pwm(force_pwm), .pwm_tick(pwm_tick),
  .pk_at_pfm_lim(pk_at_pfm_lim), .vo_above_hi(vo_above_hi), .vo_below_lo(vo_below_lo),
  .vo_below_lo2(vo_below_lo2), .pfm_mode(pfm_mode), .hs_req(hs_req), .ls_req(ls_req),
  .sleep(sleep)
);

// File: tb/tb_pfm_mode_ctrl.sv
module tb_pfm_mode_ctrl;
  localparam int PERIOD = 10;
  localparam int QUAL = 32;

  logic clk = 0, rst_n = 0;
  logic en = 0, force_pwm = 0, pwm_tick = 0, zc_det = 0, pk_below_mode = 0;
  logic pk_at_pfm_lim = 0, vo_above_hi = 0, vo_below_lo = 0, vo_below_lo2 = 0;
  logic pfm_mode, hs_req, ls_req, sleep;
  int total = 0, bad = 0;
  bit done = 0;

  pfm_mode_ctrl #(.QUAL_CYCLES(QUAL)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .force_pwm(force_pwm), .pwm_tick(pwm_tick),
    .zc_det(zc_det), .pk_below_mode(pk_below_mode), .pk_at_pfm_lim(pk_at_pfm_lim),
    .vo_above_hi(vo_above_hi), .vo_below_lo(vo_below_lo), .vo_below_lo2(vo_below_lo2),
    .pfm_mode(pfm_mode), .hs_req(hs_req), .ls_req(ls_req), .sleep(sleep)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [3:0] exp);
    logic [3:0] got;
    got = {pfm_mode, hs_req, ls_req, sleep};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: {pfm,hs,ls,sleep} actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic clear_inputs();
    force_pwm = 0; pwm_tick = 0; zc_det = 0; pk_below_mode = 0;
    pk_at_pfm_lim = 0; vo_above_hi = 0; vo_below_lo = 0; vo_below_lo2 = 0;
  endtask

  task automatic restart();
    clear_inputs(); en = 0; cyc(); en = 1;
  endtask

  task automatic ticks(int n, bit hi);
    for (int i = 0; i < n; i++) begin
      pwm_tick = 1; zc_det = 1; vo_above_hi = hi; cyc();
      pwm_tick = 0; zc_det = 0; cyc();
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] e;
    cyc(); chk("R1 reset", 4'b0000);
    rst_n = 1; en = 1; cyc(); chk("R1 after reset", 4'b0000);

    // R2/R4: run length sweep, three light-load patterns, idle cycles between ticks
    for (int pat = 0; pat < 3; pat++) begin
      restart();
      for (int k = 1; k <= QUAL + 2; k++) begin
        pwm_tick = 1; vo_above_hi = 1;
        zc_det = (pat != 1); pk_below_mode = (pat != 0);
        cyc();
        chk("R2 run sweep", (k >= QUAL) ? 4'b1001 : 4'b0000);
        pwm_tick = 0; zc_det = 0; pk_below_mode = 0;
        cyc(); cyc();
        chk("R4 idle cycle", (k >= QUAL) ? 4'b1001 : 4'b0000);
      end
    end

    // R3: break one short
    restart();
    ticks(QUAL - 1, 1);
    pwm_tick = 1; cyc(); pwm_tick = 0; cyc();
    chk("R3 broken run", 4'b0000);
    ticks(QUAL - 1, 1); chk("R3 one short after break", 4'b0000);
    ticks(1, 1); chk("R3 full run after break", 4'b1001);

    // Directed burst sequence
    restart(); ticks(QUAL, 0); chk("R5 entry to hs", 4'b1100);
    cyc(); chk("R6 hs hold", 4'b1100);
    pk_at_pfm_lim = 1; cyc(); pk_at_pfm_lim = 0; chk("R6 limit to ls", 4'b1010);
    cyc(); chk("R7 ls hold", 4'b1010);
    zc_det = 1; cyc(); zc_det = 0; chk("R7 ls to hs", 4'b1100);
    vo_above_hi = 1; cyc(); vo_above_hi = 0; chk("R6 high to final ls", 4'b1010);
    cyc(); chk("R7 final ls hold", 4'b1010);
    zc_det = 1; cyc(); zc_det = 0; chk("R7 final ls to sleep", 4'b1001);
    cyc(); chk("R8 sleep hold", 4'b1001);
    vo_below_lo = 1; cyc(); vo_below_lo = 0; chk("R8 wake", 4'b1100);
    pk_at_pfm_lim = 1; cyc(); pk_at_pfm_lim = 0; chk("R6 limit to ls", 4'b1010);
    zc_det = 1; vo_above_hi = 1; cyc(); zc_det = 0; vo_above_hi = 0;
    chk("R7 ls zc above hi to sleep", 4'b1001);
    vo_below_lo2 = 1; cyc(); vo_below_lo2 = 0; chk("R9 low2 exit", 4'b0000);
    ticks(QUAL - 1, 1); chk("R9 count restarted short", 4'b0000);
    ticks(1, 1); chk("R9 count restarted full", 4'b1001);

    // R10
    force_pwm = 1; cyc(); chk("R10 forced exit", 4'b0000);
    ticks(QUAL + 8, 1); chk("R10 no entry while forced", 4'b0000);
    force_pwm = 0; ticks(QUAL - 1, 1); chk("R10 count cleared", 4'b0000);
    ticks(1, 1); chk("R10 entry after release", 4'b1001);

    // R11
    en = 0; cyc(); chk("R11 disable exit", 4'b0000);
    ticks(QUAL + 4, 1); chk("R11 no entry while disabled", 4'b0000);
    en = 1; ticks(QUAL - 1, 1); chk("R11 count cleared", 4'b0000);

    // Exhaustive exit sweep from sleep and from hs: bits {lo2,lo,hi,lim,zc}
    for (int from_hs = 0; from_hs < 2; from_hs++) begin
      for (int v = 0; v < 32; v++) begin
        restart(); ticks(QUAL, from_hs ? 1'b0 : 1'b1);
        zc_det = v[0]; pk_at_pfm_lim = v[1]; vo_above_hi = v[2];
        vo_below_lo = v[3]; vo_below_lo2 = v[4];
        cyc();
        if (v[4])                      e = 4'b0000;
        else if (from_hs == 0)         e = v[3] ? 4'b1100 : 4'b1001;
        else if (v[2] || v[1])         e = 4'b1010;
        else                           e = 4'b1100;
        chk(from_hs ? "R6 R9 R12 hs sweep" : "R8 R9 R12 sleep sweep", e);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule